// File: doc/BRIEF.md
# Posted-Write Parity Error Handler for a Two-Port Bus Bridge

This block sits beside the posted-write data path of a two-port PCI-to-PCI bridge and looks after data parity on writes that the bridge accepts as target, in both directions. Each accepted data phase is checked for even parity over the address/data and byte-enable lines against the parity bit, which arrives one clock after the data. A mismatch pulses the PERR output of the initiating bus when that side's parity response is enabled, and it sets that side's sticky parity-detected status bit. The write still completes normally. The accepted data leaves the block with a tag that marks whether its parity was bad.

When the bridge later drives tagged data onto the opposite bus, the block generates that bus's parity bit. A bad tag inverts the bit, so the fault reaches the far side unchanged. During downstream writes the block also watches the secondary-side PERR input from the target. A report from the target can set the secondary data-parity status bit. It raises the primary system error only when the bridge did not forward that fault itself and every enable allows it.

Top module: `pbr_parity_guard`

## Requirements
- R1: When a primary-side data phase with `pi_vld`=1 in cycle T fails even parity, `pri_perr_n` goes low for exactly cycle T+2, provided `pri_per_en`=1. Even parity means that the XOR of `pi_ad`, `pi_cbe` and `pi_par` (sampled in T+1) is 0. With `pri_per_en`=0, or with correct parity, `pri_perr_n` stays high.
- R2: The same rule holds on the secondary side, using `si_*`, `sec_perr_n` and `sec_per_en`.
- R3: A parity mismatch found as target sets the status bit of the initiating side, whatever the enable. Bit 0 is primary detected and bit 1 is secondary detected. The bit is visible in cycle T+2.
- R4: Every accepted data phase in cycle T appears on the tag outputs in cycle T+2, with its address/data and byte enables. The bad flag is 1 exactly when parity failed. There is no abort: a phase with a bad flag is still delivered.
- R5: An egress data phase with `po_vld` or `so_vld`=1 in cycle T yields a parity output in cycle T+1. The value is the even parity of the data and byte enables, XORed with the bad flag. The parity output is 0 in all other cycles.
- R6: `tgt_perr_n`=0 with `dn_wr_act`=1 in cycle T sets status bit 2 (secondary data parity reported) in cycle T+1, but only if `sec_per_en`=1. When `dn_wr_act`=0, the report is ignored.
- R7: On such a report, `pri_serr_n` goes low for exactly cycle T+1 and status bit 3 (signaled system error) is set, but only when all of these hold: `serr_en`=1, `pw_serr_dis`=0, `sec_per_en`=1, `pri_per_en`=1 and `dn_fwd`=0. Otherwise `pri_serr_n` stays high and bit 3 is unchanged.
- R8: Status bits are sticky. Reset clears them. Writing a 1 on `stat_clr[i]` in cycle T clears bit i in cycle T+1. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_per_en | input | 1 | Primary parity error response enable |
| sec_per_en | input | 1 | Secondary parity error response enable |
| serr_en | input | 1 | System error enable |
| pw_serr_dis | input | 1 | Suppress system error for posted-write parity |
| pi_vld | input | 1 | Primary data phase accepted as target |
| pi_ad | input | 32 | Primary address/data |
| pi_cbe | input | 4 | Primary byte enables |
| pi_par | input | 1 | Primary parity, one clock after data |
| si_vld | input | 1 | Secondary data phase accepted as target |
| si_ad | input | 32 | Secondary address/data |
| si_cbe | input | 4 | Secondary byte enables |
| si_par | input | 1 | Secondary parity, one clock after data |
| po_vld | input | 1 | Upstream data phase driven on primary |
| po_ad | input | 32 | Data driven on primary |
| po_cbe | input | 4 | Byte enables driven on primary |
| po_bad | input | 1 | Tag of that data: forwarded bad parity |
| po_par | output | 1 | Parity to drive on primary |
| so_vld | input | 1 | Downstream data phase driven on secondary |
| so_ad | input | 32 | Data driven on secondary |
| so_cbe | input | 4 | Byte enables driven on secondary |
| so_bad | input | 1 | Tag of that data: forwarded bad parity |
| so_par | output | 1 | Parity to drive on secondary |
| pri_perr_n | output | 1 | Primary parity error, active low |
| sec_perr_n | output | 1 | Secondary parity error, active low |
| pt_vld | output | 1 | Tagged entry from primary ingress |
| pt_ad | output | 32 | Entry data |
| pt_cbe | output | 4 | Entry byte enables |
| pt_bad | output | 1 | Entry carries bad parity |
| st_vld | output | 1 | Tagged entry from secondary ingress |
| st_ad | output | 32 | Entry data |
| st_cbe | output | 4 | Entry byte enables |
| st_bad | output | 1 | Entry carries bad parity |
| tgt_perr_n | input | 1 | Secondary target parity error report, active low |
| dn_wr_act | input | 1 | A downstream write is in progress on secondary |
| dn_fwd | input | 1 | Reported phase carried a forwarded bad tag |
| pri_serr_n | output | 1 | Primary system error, active low |
| stat_clr | input | 4 | Write-one-to-clear for status bits |
| stat | output | 4 | Sticky status bits |

## Verification
The ingress results are all due two cycles after the data phase: the PERR pulses, the tags and the detected-status bits. This is because parity arrives one clock late and the comparison is then registered once. Egress parity, the system-error pulse and the report status are due one cycle after their stimulus. The driver pushes each expected pulse, tag and parity value into a queue stamped with that due cycle. The monitor then compares every output on every falling edge, expecting the idle value wherever no entry is due. Status bits are compared against a bench model only after the pipeline has drained, and the set-versus-clear collision is timed so that both land on the same edge.

// File: rtl/pbr_pkg.sv
// Shared definitions for the bridge parity handler.
// Assumes status bit positions are fixed for software visibility.
package pbr_pkg;
    localparam int ST_PRI_DET = 0;   // primary parity error detected as target
    localparam int ST_SEC_DET = 1;   // secondary parity error detected as target
    localparam int ST_SEC_RPT = 2;   // secondary target reported data parity
    localparam int ST_PRI_SSE = 3;   // primary signaled system error
    localparam int ST_NUM     = 4;
endpackage

// File: rtl/pbr_par_check.sv
// Ingress parity checker for one bus side.
// Checks even parity of a data phase accepted as target. Parity arrives one
// clock after the data. It pulses PERR two clocks after the phase when
// enabled and emits the data with a bad-parity tag in the same cycle.
// Assumes per_en is stable around the phase.
module pbr_par_check #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dvld,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            par,
    input  logic            per_en,
    output logic            err_now,
    output logic            perr_n,
    output logic            ent_vld,
    output logic [AD_W-1:0] ent_ad,
    output logic [BE_W-1:0] ent_cbe,
    output logic            ent_bad
);
    logic            s1_vld;
    logic            s1_sum;
    logic [AD_W-1:0] s1_ad;
    logic [BE_W-1:0] s1_cbe;

    // Stage 1: capture the phase and its computed parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_sum <= 1'b0;
            s1_ad  <= '0;
            s1_cbe <= '0;
        end else begin
            s1_vld <= dvld;
            s1_sum <= ^{ad, cbe};
            s1_ad  <= ad;
            s1_cbe <= cbe;
        end
    end

    // Mismatch against the late parity bit.
    always_comb err_now = s1_vld & (s1_sum ^ par);

    // Stage 2: PERR pulse and tagged entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_n  <= 1'b1;
            ent_vld <= 1'b0;
            ent_ad  <= '0;
            ent_cbe <= '0;
            ent_bad <= 1'b0;
        end else begin
            perr_n  <= ~(err_now & per_en);
            ent_vld <= s1_vld;
            ent_ad  <= s1_ad;
            ent_cbe <= s1_cbe;
            ent_bad <= err_now;
        end
    end

    AST_PERR_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(dvld, 2)); // R1
    AST_PERR_MEANS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> (ent_vld && ent_bad)); // R2
    AST_TAG_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld |-> $past(dvld, 2)); // R4
endmodule

// File: rtl/pbr_par_gen.sv
// Egress parity generator for one bus side.
// Drives the parity bit one clock after a data phase, inverted when the data
// carries a forwarded bad-parity tag. Drives 0 when no phase is present.
module pbr_par_gen #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_vld,
    input  logic [AD_W-1:0] out_ad,
    input  logic [BE_W-1:0] out_cbe,
    input  logic            out_bad,
    output logic            par_o
);
    // Registered parity, corrupted on purpose for bad-tagged data.
    always_ff @(posedge clk) begin
        if (!rst_n) par_o <= 1'b0;
        else        par_o <= out_vld & ((^{out_ad, out_cbe}) ^ out_bad);
    end

    AST_PAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        par_o |-> $past(out_vld)); // R5
endmodule

// File: rtl/pbr_serr_qual.sv
// Qualifies a parity report from the secondary target during a downstream write.
// Produces status set strobes and a one-clock primary system error pulse.
// Assumes ent_fwd is the bad tag of the entry that the report refers to.
module pbr_serr_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_perr_n,
    input  logic dn_wr_act,
    input  logic ent_fwd,
    input  logic sec_per_en,
    input  logic pri_per_en,
    input  logic serr_en,
    input  logic pw_dis,
    output logic rpt_now,
    output logic sse_now,
    output logic serr_n
);
    logic hit;

    // Decode the report and the five-way system error condition.
    always_comb begin
        hit     = ~tgt_perr_n & dn_wr_act;
        rpt_now = hit & sec_per_en;
        sse_now = rpt_now & pri_per_en & serr_en & ~pw_dis & ~ent_fwd;
    end

    // One-clock system error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_n <= 1'b1;
        else        serr_n <= ~sse_now;
    end

    AST_SERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(!tgt_perr_n && dn_wr_act && !ent_fwd && serr_en)); // R7
endmodule

// File: rtl/pbr_parity_guard.sv
// Top of the posted-write parity handler of a two-port bridge.
// Holds one ingress checker and one egress generator per side, the target
// report qualifier and the sticky write-one-to-clear status register.
// Assumes config enables come from decoded registers outside this block.
module pbr_parity_guard
    import pbr_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_per_en,
    input  logic              sec_per_en,
    input  logic              serr_en,
    input  logic              pw_serr_dis,
    input  logic              pi_vld,
    input  logic [AD_W-1:0]   pi_ad,
    input  logic [BE_W-1:0]   pi_cbe,
    input  logic              pi_par,
    input  logic              si_vld,
    input  logic [AD_W-1:0]   si_ad,
    input  logic [BE_W-1:0]   si_cbe,
    input  logic              si_par,
    input  logic              po_vld,
    input  logic [AD_W-1:0]   po_ad,
    input  logic [BE_W-1:0]   po_cbe,
    input  logic              po_bad,
    output logic              po_par,
    input  logic              so_vld,
    input  logic [AD_W-1:0]   so_ad,
    input  logic [BE_W-1:0]   so_cbe,
    input  logic              so_bad,
    output logic              so_par,
    output logic              pri_perr_n,
    output logic              sec_perr_n,
    output logic              pt_vld,
    output logic [AD_W-1:0]   pt_ad,
    output logic [BE_W-1:0]   pt_cbe,
    output logic              pt_bad,
    output logic              st_vld,
    output logic [AD_W-1:0]   st_ad,
    output logic [BE_W-1:0]   st_cbe,
    output logic              st_bad,
    input  logic              tgt_perr_n,
    input  logic              dn_wr_act,
    input  logic              dn_fwd,
    output logic              pri_serr_n,
    input  logic [ST_NUM-1:0] stat_clr,
    output logic [ST_NUM-1:0] stat
);
    logic              pri_err, sec_err, rpt_now, sse_now;
    logic [ST_NUM-1:0] st_set;

    pbr_par_check #(.AD_W(AD_W), .BE_W(BE_W)) u_pchk (
        .clk(clk), .rst_n(rst_n), .dvld(pi_vld), .ad(pi_ad), .cbe(pi_cbe),
        .par(pi_par), .per_en(pri_per_en), .err_now(pri_err), .perr_n(pri_perr_n),
        .ent_vld(pt_vld), .ent_ad(pt_ad), .ent_cbe(pt_cbe), .ent_bad(pt_bad));

    pbr_par_check #(.AD_W(AD_W), .BE_W(BE_W)) u_schk (
        .clk(clk), .rst_n(rst_n), .dvld(si_vld), .ad(si_ad), .cbe(si_cbe),
        .par(si_par), .per_en(sec_per_en), .err_now(sec_err), .perr_n(sec_perr_n),
        .ent_vld(st_vld), .ent_ad(st_ad), .ent_cbe(st_cbe), .ent_bad(st_bad));

    pbr_par_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_pgen (
        .clk(clk), .rst_n(rst_n), .out_vld(po_vld), .out_ad(po_ad),
        .out_cbe(po_cbe), .out_bad(po_bad), .par_o(po_par));

    pbr_par_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_sgen (
        .clk(clk), .rst_n(rst_n), .out_vld(so_vld), .out_ad(so_ad),
        .out_cbe(so_cbe), .out_bad(so_bad), .par_o(so_par));

    pbr_serr_qual u_serr (
        .clk(clk), .rst_n(rst_n), .tgt_perr_n(tgt_perr_n), .dn_wr_act(dn_wr_act),
        .ent_fwd(dn_fwd), .sec_per_en(sec_per_en), .pri_per_en(pri_per_en),
        .serr_en(serr_en), .pw_dis(pw_serr_dis), .rpt_now(rpt_now),
        .sse_now(sse_now), .serr_n(pri_serr_n));

    // Gather the set strobes by status position.
    always_comb begin
        st_set             = '0;
        st_set[ST_PRI_DET] = pri_err;
        st_set[ST_SEC_DET] = sec_err;
        st_set[ST_SEC_RPT] = rpt_now;
        st_set[ST_PRI_SSE] = sse_now;
    end

    for (genvar i = 0; i < ST_NUM; i++) begin : g_stat
        // Sticky bit: set wins over write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n) stat[i] <= 1'b0;
            else        stat[i] <= st_set[i] | (stat[i] & ~stat_clr[i]);
        end

        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stat[i]) && !$past(stat_clr[i])) |-> stat[i]); // R8
    end

    AST_SSE_WITH_SERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_PRI_SSE]) |-> !pri_serr_n); // R7
    AST_PDET_WITH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_PRI_DET]) |-> (pt_vld && pt_bad)); // R3
endmodule

// File: tb/pbr_parity_guard_test.sv
module pbr_parity_guard_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic pri_per_en, sec_per_en, serr_en, pw_serr_dis;
    logic pi_vld, pi_par, si_vld, si_par, po_vld, po_bad, so_vld, so_bad;
    logic [31:0] pi_ad, si_ad, po_ad, so_ad, pt_ad, st_ad;
    logic [3:0]  pi_cbe, si_cbe, po_cbe, so_cbe, pt_cbe, st_cbe;
    logic po_par, so_par, pri_perr_n, sec_perr_n, pt_vld, pt_bad, st_vld, st_bad;
    logic tgt_perr_n, dn_wr_act, dn_fwd, pri_serr_n;
    logic [3:0] stat_clr, stat;

    pbr_parity_guard uut (.*);

    typedef struct { int due; int kind; logic [31:0] val; logic flag; } exp_t;
    exp_t q[$];
    int cyc = 0, n_chk = 0, n_bad = 0;
    bit mon_on = 0, done = 0;
    logic nxt_pp = 0, nxt_sp = 0;
    logic [3:0] model = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // Monitor: compare all outputs each cycle against queued expectations.
    always @(negedge clk) begin
        logic e_pp, e_sp, e_se, e_pt, e_ptb, e_st, e_stb, e_pop, e_sop;
        logic [31:0] e_pta, e_sta;
        if (mon_on && !done) begin
            e_pp = 1; e_sp = 1; e_se = 1; e_pt = 0; e_ptb = 0; e_st = 0; e_stb = 0;
            e_pop = 0; e_sop = 0; e_pta = 0; e_sta = 0;
            foreach (q[i]) if (q[i].due == cyc) begin
                case (q[i].kind)
                    0: e_pp = 0;
                    1: e_sp = 0;
                    2: e_se = 0;
                    3: begin e_pt = 1; e_pta = q[i].val; e_ptb = q[i].flag; end
                    4: begin e_st = 1; e_sta = q[i].val; e_stb = q[i].flag; end
                    5: e_sop = q[i].flag;
                    6: e_pop = q[i].flag;
                    default: ;
                endcase
            end
            cmp("R1 pri_perr_n", {31'b0, pri_perr_n}, {31'b0, e_pp});
            cmp("R2 sec_perr_n", {31'b0, sec_perr_n}, {31'b0, e_sp});
            cmp("R7 pri_serr_n", {31'b0, pri_serr_n}, {31'b0, e_se});
            cmp("R4 pt_vld", {31'b0, pt_vld}, {31'b0, e_pt});
            if (e_pt) begin
                cmp("R4 pt_ad", pt_ad, e_pta);
                cmp("R4 pt_bad", {31'b0, pt_bad}, {31'b0, e_ptb});
            end
            cmp("R4 st_vld", {31'b0, st_vld}, {31'b0, e_st});
            if (e_st) begin
                cmp("R4 st_ad", st_ad, e_sta);
                cmp("R4 st_bad", {31'b0, st_bad}, {31'b0, e_stb});
            end
            cmp("R5 so_par", {31'b0, so_par}, {31'b0, e_sop});
            cmp("R5 po_par", {31'b0, po_par}, {31'b0, e_pop});
            for (int i = q.size() - 1; i >= 0; i--) if (q[i].due <= cyc) q.delete(i);
        end
    end

    task automatic push(input int due, input int kind, input logic [31:0] val, input logic flag);
        exp_t e;
        e.due = due; e.kind = kind; e.val = val; e.flag = flag;
        q.push_back(e);
    endtask

    // One driver cycle: apply late parity, return strobes to idle.
    task automatic tick();
        @(negedge clk);
        pi_par = nxt_pp; si_par = nxt_sp; nxt_pp = 0; nxt_sp = 0;
        pi_vld = 0; si_vld = 0; po_vld = 0; so_vld = 0; po_bad = 0; so_bad = 0;
        tgt_perr_n = 1; dn_wr_act = 0; dn_fwd = 0; stat_clr = 0;
    endtask

    task automatic pri_in(input logic [31:0] ad, input logic [3:0] be, input logic bad);
        pi_vld = 1; pi_ad = ad; pi_cbe = be; nxt_pp = (^{ad, be}) ^ bad;
        push(cyc + 2, 3, ad, bad);
        if (bad && pri_per_en) push(cyc + 2, 0, 0, 1);
        if (bad) model[0] = 1;
    endtask

    task automatic sec_in(input logic [31:0] ad, input logic [3:0] be, input logic bad);
        si_vld = 1; si_ad = ad; si_cbe = be; nxt_sp = (^{ad, be}) ^ bad;
        push(cyc + 2, 4, ad, bad);
        if (bad && sec_per_en) push(cyc + 2, 1, 0, 1);
        if (bad) model[1] = 1;
    endtask

    task automatic so_out(input logic [31:0] ad, input logic [3:0] be, input logic bad);
        so_vld = 1; so_ad = ad; so_cbe = be; so_bad = bad;
        push(cyc + 1, 5, 0, (^{ad, be}) ^ bad);
    endtask

    task automatic po_out(input logic [31:0] ad, input logic [3:0] be, input logic bad);
        po_vld = 1; po_ad = ad; po_cbe = be; po_bad = bad;
        push(cyc + 1, 6, 0, (^{ad, be}) ^ bad);
    endtask

    task automatic report(input logic fwd, input logic act);
        tgt_perr_n = 0; dn_wr_act = act; dn_fwd = fwd;
        if (act && sec_per_en) model[2] = 1;
        if (act && sec_per_en && pri_per_en && serr_en && !pw_serr_dis && !fwd) begin
            push(cyc + 1, 2, 0, 1);
            model[3] = 1;
        end
    endtask

    task automatic drain();
        repeat (4) tick();
    endtask

    task automatic chk_stat(input string req);
        cmp(req, {28'b0, stat}, {28'b0, model});
    endtask

    task automatic clear_all();
        tick(); stat_clr = 4'hF; model = 0;
        drain();
    endtask

    task automatic cfg(input logic pp, input logic sp, input logic se, input logic dis);
        tick(); pri_per_en = pp; sec_per_en = sp; serr_en = se; pw_serr_dis = dis;
        drain();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired before end of test (all requirements)");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pri_per_en = 1; sec_per_en = 1; serr_en = 1; pw_serr_dis = 0;
        pi_vld = 0; pi_ad = 0; pi_cbe = 0; pi_par = 0; si_vld = 0; si_ad = 0; si_cbe = 0;
        si_par = 0; po_vld = 0; po_ad = 0; po_cbe = 0; po_bad = 0; so_vld = 0; so_ad = 0;
        so_cbe = 0; so_bad = 0; tgt_perr_n = 1; dn_wr_act = 0; dn_fwd = 0; stat_clr = 0;
        repeat (4) @(negedge clk);
        // Reset state (R8 reset clears status; R1 R2 R7 idle high).
        cmp("R8 reset stat", {28'b0, stat}, 0);
        cmp("R1 reset pri_perr_n", {31'b0, pri_perr_n}, 1);
        cmp("R2 reset sec_perr_n", {31'b0, sec_perr_n}, 1);
        cmp("R7 reset pri_serr_n", {31'b0, pri_serr_n}, 1);
        tick(); rst_n = 1;
        tick(); mon_on = 1;

        // R4: good parity on both sides, no PERR, bad flag clear.
        tick(); pri_in(32'hA5A5_0001, 4'hF, 0); sec_in(32'h1234_5678, 4'h3, 0);
        tick(); pri_in(32'h0000_0000, 4'h0, 0);
        drain(); chk_stat("R3 no detect on good parity");

        // R1 R3: primary bad parity with enable.
        tick(); pri_in(32'hDEAD_BEEF, 4'hC, 1);
        drain(); chk_stat("R3 primary detected bit");

        // R2 R3: secondary bad parity with enable.
        tick(); sec_in(32'hCAFE_F00D, 4'h1, 1);
        drain(); chk_stat("R3 secondary detected bit");
        clear_all(); chk_stat("R8 clear all");

        // R1: enable off, no PERR but status still set (R3).
        cfg(0, 0, 1, 0);
        tick(); pri_in(32'h0F0F_0F0F, 4'h5, 1); sec_in(32'hF0F0_F0F0, 4'hA, 1);
        drain(); chk_stat("R3 detect without enable");
        cfg(1, 1, 1, 0); clear_all();

        // R1 R4: back-to-back burst with mixed parity.
        for (int k = 0; k < 8; k++) begin
            tick(); pri_in(32'h1000_0000 + k * 32'h0101, 4'(k), k[0]);
            sec_in(32'h2000_0000 ^ k, 4'(15 - k), k[1]);
        end
        drain(); chk_stat("R3 burst detect");
        clear_all();

        // R5: egress parity with and without forwarded bad tag.
        for (int k = 0; k < 6; k++) begin
            tick(); so_out(32'h3333_0000 + k, 4'(k * 3), k[0]);
            po_out(32'h4444_0000 - k, 4'(k), k[1]);
        end
        drain();

        // R6 R7: full qualification raises SERR.
        tick(); report(0, 1);
        drain(); chk_stat("R7 SERR and report status");
        clear_all();

        // R7: forwarded error gives no SERR, but R6 report bit set.
        tick(); report(1, 1);
        drain(); chk_stat("R7 forwarded excluded / R6 set");
        clear_all();

        // R7: each remaining condition removed in turn.
        cfg(1, 1, 0, 0); tick(); report(0, 1); drain(); chk_stat("R7 serr_en off");
        clear_all();
        cfg(1, 1, 1, 1); tick(); report(0, 1); drain(); chk_stat("R7 disable set");
        clear_all();
        cfg(0, 1, 1, 0); tick(); report(0, 1); drain(); chk_stat("R7 primary enable off");
        clear_all();
        cfg(1, 0, 1, 0); tick(); report(0, 1); drain(); chk_stat("R6 secondary enable off");
        clear_all();
        cfg(1, 1, 1, 0);

        // R6: report outside a downstream write is ignored.
        tick(); report(0, 0);
        drain(); chk_stat("R6 ignored without write");

        // R8: set in same cycle as clear wins, then clear alone works.
        tick(); pri_in(32'h5555_AAAA, 4'h9, 1);
        tick(); stat_clr = 4'b0001;
        drain(); chk_stat("R8 set wins over clear");
        tick(); stat_clr = 4'b0001; model[0] = 0;
        drain(); chk_stat("R8 write one clears");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule